// File: doc/BRIEF.md
# FIFO Fill-Band Flag with Loadable Offsets

This block watches the occupancy of a 512-word FIFO and raises a single status flag whenever the fill level is near either end of the memory. The lower band is set by an almost-empty offset (X). The upper band is set by an almost-full offset (Y). The flag is high when the count sits inside either band.

Both offsets are 8-bit values that default to 128. Software or a neighbouring controller can replace them through the FIFO's own data input. This is allowed only in the window after a reset and before the first word is stored. An active-low program enable selects the load. On the first sampled edge the low data byte goes into both offsets. On an immediately following edge the byte goes into the almost-full offset alone.

While a load is being requested, the block raises a write-inhibit so that the surrounding FIFO stores nothing. The FIFO's write strobe and occupancy count are inputs. The memory and the counters themselves are elsewhere.

Top module: `fill_band_flag`

## Requirements
- R1: At every rising clock edge the flag register is loaded with 1 when the sampled `fill_cnt` is less than or equal to X, or greater than or equal to 512 − Y, and with 0 otherwise. The offsets used are the ones in effect before that edge, and the result is visible after that edge.
- R2: After reset, with no loading, X = Y = 128. The flag is therefore high for counts 0..128 and 384..512, and low for counts 129..383.
- R3: While `rst_n` is low, `band_flag` is high, from the moment reset is asserted.
- R4: The first rising edge with `prog_n` = 0 inside the load window copies `data_lo` into both X and Y.
- R5: If `prog_n` is still 0 on the very next rising edge, `data_lo` on that edge is copied into Y only, and X keeps its value.
- R6: Once a load has started, nothing changes X or Y until the next reset. This covers a third or later consecutive edge with `prog_n` = 0, and any edge with `prog_n` = 0 after `prog_n` has returned high.
- R7: An accepted write (`word_wr` = 1 while `wr_block` = 0) closes the load window. After that, `prog_n` is ignored and the offsets stay as they are. A reset reopens the window and restores 128 in both offsets.
- R8: `wr_block` is 1 exactly while `prog_n` = 0 and the load window is open. A `word_wr` that arrives while `wr_block` = 1 is not a stored word and does not close the window.
- R9: The offsets span the full 8-bit range:
  - With X = Y = 255, counts 255 and 257 give a high flag and count 256 gives a low flag.
  - With X = Y = 0, only counts 0 and 512 give a high flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n | input | 1 | Active-low offset load enable |
| data_lo | input | 8 | Low byte of the FIFO data input, source of the offsets |
| word_wr | input | 1 | FIFO requests to store a word this cycle |
| fill_cnt | input | 10 | Current number of stored words (0..512) |
| band_flag | output | 1 | High when the fill level is within either offset band |
| wr_block | output | 1 | High while a load request holds off storage |

## Verification
Two events can land on the same clock edge. One is a write request on an edge that is also loading an offset. The other is the flag evaluation on an edge that changes the offsets. The bench raises `word_wr` together with `prog_n` low on the first load edge and then loads Y on the second edge. A window wrongly closed by the blocked write would show up as a wrong upper threshold. Flag values are only judged on later edges, where the new offsets are in effect, at thresholds chosen so that each wrong outcome (a lost Y load, a late third edge, a load after a gap) moves a boundary and flips a sampled flag.

// File: rtl/fbf_pkg.sv
`timescale 1ns/1ps
package fbf_pkg;
    // Load sequence position inside the window after reset
    typedef enum logic [1:0] {
        LD_OPEN  = 2'd0,   // no load seen yet
        LD_FIRST = 2'd1,   // both offsets loaded on the previous edge
        LD_SHUT  = 2'd2    // loading finished, offsets frozen
    } ld_step_e;
endpackage

// File: rtl/fbf_offset_loader.sv
`timescale 1ns/1ps
module fbf_offset_loader #(
    parameter int OFS_W       = 8,
    parameter int DEFAULT_OFS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prog_n,
    input  logic [OFS_W-1:0]     data_lo,
    input  logic                 word_wr,
    output logic [OFS_W-1:0]     x_ofs,
    output logic [OFS_W-1:0]     y_ofs,
    output logic                 win_open,
    output fbf_pkg::ld_step_e    step,
    output logic                 wr_block
);
    import fbf_pkg::*;

    localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEFAULT_OFS);

    typedef struct packed {
        logic             win;
        ld_step_e         step;
        logic [OFS_W-1:0] x;
        logic [OFS_W-1:0] y;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.win) begin
            if (!prog_n) begin
                case (st_q.step)
                    LD_OPEN: begin
                        st_d.x    = data_lo;
                        st_d.y    = data_lo;
                        st_d.step = LD_FIRST;
                    end
                    LD_FIRST: begin
                        st_d.y    = data_lo;
                        st_d.step = LD_SHUT;
                    end
                    default: ;
                endcase
            end else begin
                if (st_q.step == LD_FIRST) begin
                    st_d.step = LD_SHUT;
                end
                // a write counts only when it is not held off
                if (word_wr) begin
                    st_d.win = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{win: 1'b1, step: LD_OPEN, x: DEF_V, y: DEF_V};
        end else begin
            st_q <= st_d;
        end
    end

    assign x_ofs    = st_q.x;
    assign y_ofs    = st_q.y;
    assign win_open = st_q.win;
    assign step     = st_q.step;
    assign wr_block = st_q.win & ~prog_n;
endmodule

// File: rtl/fbf_band_compare.sv
`timescale 1ns/1ps
module fbf_band_compare #(
    parameter int DEPTH = 512,
    parameter int OFS_W = 8,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fill_cnt,
    input  logic [OFS_W-1:0] x_ofs,
    input  logic [OFS_W-1:0] y_ofs,
    output logic             band_flag
);
    localparam logic [CNT_W-1:0] DEPTH_V = CNT_W'(DEPTH);

    logic [CNT_W-1:0] hi_lim;
    logic             low_band, high_band;
    logic             flag_d, flag_q;

    always_comb begin
        hi_lim    = DEPTH_V - CNT_W'(y_ofs);
        low_band  = (fill_cnt <= CNT_W'(x_ofs));
        high_band = (fill_cnt >= hi_lim);
        flag_d    = low_band | high_band;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign band_flag = flag_q;
endmodule

// File: rtl/fill_band_flag.sv
`timescale 1ns/1ps
module fill_band_flag #(
    parameter int DEPTH       = 512,
    parameter int OFS_W       = 8,
    parameter int DEFAULT_OFS = 128,
    parameter int CNT_W       = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_n,
    input  logic [OFS_W-1:0] data_lo,
    input  logic             word_wr,
    input  logic [CNT_W-1:0] fill_cnt,
    output logic             band_flag,
    output logic             wr_block
);
    logic [OFS_W-1:0]  x_ofs, y_ofs;
    logic              ld_win;
    fbf_pkg::ld_step_e ld_step;

    fbf_offset_loader #(
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEFAULT_OFS)
    ) u_loader (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_n   (prog_n),
        .data_lo  (data_lo),
        .word_wr  (word_wr),
        .x_ofs    (x_ofs),
        .y_ofs    (y_ofs),
        .win_open (ld_win),
        .step     (ld_step),
        .wr_block (wr_block)
    );

    fbf_band_compare #(
        .DEPTH (DEPTH),
        .OFS_W (OFS_W),
        .CNT_W (CNT_W)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_cnt  (fill_cnt),
        .x_ofs     (x_ofs),
        .y_ofs     (y_ofs),
        .band_flag (band_flag)
    );
endmodule

// File: rtl/fill_band_flag_chk.sv
`timescale 1ns/1ps
module fill_band_flag_chk #(
    parameter int DEPTH = 512,
    parameter int OFS_W = 8,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prog_n,
    input logic [OFS_W-1:0]  data_lo,
    input logic              word_wr,
    input logic [CNT_W-1:0]  fill_cnt,
    input logic              band_flag,
    input logic              wr_block,
    input logic              win_open,
    input fbf_pkg::ld_step_e step,
    input logic [OFS_W-1:0]  x_ofs,
    input logic [OFS_W-1:0]  y_ofs
);
    import fbf_pkg::*;

    // R3: flag held high while reset is applied
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_flag_in_reset_r3: assert (band_flag == 1'b1);
        end
    end

    // R1: flag follows the band test of the previous edge's inputs
    p_band_eval_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> band_flag ==
            (($past(fill_cnt) <= CNT_W'($past(x_ofs))) ||
             ($past(fill_cnt) >= (CNT_W'(DEPTH) - CNT_W'($past(y_ofs))))));

    // R4: first load edge copies the byte into both offsets
    p_first_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && win_open && step == LD_OPEN) |=>
            (x_ofs == $past(data_lo)) && (y_ofs == $past(data_lo)));

    // R5: second consecutive edge touches only the almost-full offset
    p_second_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && win_open && step == LD_FIRST) |=>
            $stable(x_ofs) && (y_ofs == $past(data_lo)));

    // R6: offsets frozen once loading has finished
    p_frozen_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == LD_SHUT) |=> $stable(x_ofs) && $stable(y_ofs));

    // R7: offsets frozen once the window has closed
    p_frozen_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(x_ofs) && $stable(y_ofs) && !win_open);

    // R8: a held-off write leaves the window open
    p_blocked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_wr && wr_block) |=> win_open);
endmodule

bind fill_band_flag fill_band_flag_chk #(
    .DEPTH (DEPTH),
    .OFS_W (OFS_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_n    (prog_n),
    .data_lo   (data_lo),
    .word_wr   (word_wr),
    .fill_cnt  (fill_cnt),
    .band_flag (band_flag),
    .wr_block  (wr_block),
    .win_open  (ld_win),
    .step      (ld_step),
    .x_ofs     (x_ofs),
    .y_ofs     (y_ofs)
);

// File: tb/fill_band_flag_tb.sv
`timescale 1ns/1ps
module fill_band_flag_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       prog_n = 1'b1;
    logic [7:0] data_lo = '0;
    logic       word_wr = 1'b0;
    logic [9:0] fill_cnt = '0;
    logic       band_flag, wr_block;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fill_band_flag u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_n    (prog_n),
        .data_lo   (data_lo),
        .word_wr   (word_wr),
        .fill_cnt  (fill_cnt),
        .band_flag (band_flag),
        .wr_block  (wr_block)
    );

    // default offsets: {count, expected flag}, R2 / R1
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {10'd0,   1'b1}, {10'd128, 1'b1}, {10'd129, 1'b0}, {10'd255, 1'b0},
        {10'd256, 1'b0}, {10'd383, 1'b0}, {10'd384, 1'b1}, {10'd512, 1'b1}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic flag_at(input logic [9:0] cnt, input logic exp, input string req);
        @(negedge clk);
        fill_cnt = cnt;
        prog_n = 1'b1;
        word_wr = 1'b0;
        @(posedge clk);
        #1;
        chk($sformatf("%s count %0d", req, cnt), band_flag, exp);
    endtask

    task automatic drive(input logic p, input logic [7:0] d, input logic w);
        @(negedge clk);
        prog_n = p;
        data_lo = d;
        word_wr = w;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        prog_n = 1'b1;
        word_wr = 1'b0;
        fill_cnt = 10'd200;
        rst_n = 1'b0;
        #1;
        chk("R3 flag high in reset", band_flag, 1'b1);
        repeat (2) @(negedge clk);
        chk("R3 flag held in reset", band_flag, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        #1;
        do_reset();
        chk("R8 no block with prog high", wr_block, 1'b0);

        // R2 / R1: table walk under default offsets
        for (int i = 0; i < NV; i++) begin
            flag_at(VEC[i][10:1], VEC[i][0], "R2 default band");
        end

        // R4 / R5 / R6 / R8: load with a colliding write on the first edge
        do_reset();
        @(negedge clk);
        prog_n = 1'b0;
        data_lo = 8'd20;
        word_wr = 1'b1;
        #1;
        chk("R8 block during load", wr_block, 1'b1);
        @(posedge clk);
        #1;
        drive(1'b0, 8'd40, 1'b0);   // second edge: Y only (R5)
        drive(1'b0, 8'd99, 1'b0);   // third edge: ignored (R6)
        flag_at(10'd20,  1'b1, "R4 X loaded");
        flag_at(10'd21,  1'b0, "R4 X loaded");
        flag_at(10'd471, 1'b0, "R5 Y reloaded, R6 third edge ignored");
        flag_at(10'd472, 1'b1, "R5 Y reloaded");

        // R7: reset restores defaults, write closes the window
        do_reset();
        flag_at(10'd128, 1'b1, "R7 defaults after reset");
        flag_at(10'd129, 1'b0, "R7 defaults after reset");
        drive(1'b1, 8'd0, 1'b1);    // accepted write
        @(negedge clk);
        prog_n = 1'b0;
        data_lo = 8'd5;
        word_wr = 1'b0;
        #1;
        chk("R8 no block after window closed", wr_block, 1'b0);
        @(posedge clk);
        #1;
        flag_at(10'd6,   1'b1, "R7 load ignored after write");
        flag_at(10'd129, 1'b0, "R7 load ignored after write");

        // R9 top of range, R6 load after a gap
        do_reset();
        drive(1'b0, 8'd255, 1'b0);
        drive(1'b1, 8'd0, 1'b0);
        drive(1'b0, 8'd0, 1'b0);    // after gap: ignored
        flag_at(10'd255, 1'b1, "R9 X=255, R6 gap load ignored");
        flag_at(10'd256, 1'b0, "R9 X=Y=255");
        flag_at(10'd257, 1'b1, "R9 Y=255");

        // R9 bottom of range
        do_reset();
        drive(1'b0, 8'd0, 1'b0);
        flag_at(10'd0,   1'b1, "R9 X=0");
        flag_at(10'd1,   1'b0, "R9 X=0");
        flag_at(10'd511, 1'b0, "R9 Y=0");
        flag_at(10'd512, 1'b1, "R9 Y=0");

        // R1: flag follows the count edge by edge
        flag_at(10'd3, 1'b0, "R1 registered update");
        flag_at(10'd0, 1'b1, "R1 registered update");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule